// File: doc/BRIEF.md
# Keyed Flash Write Protection Unit

This unit sits between the system write bus and the non-volatile memory controller. It decides, one bus write at a time, whether a write may go on to program memory, data EEPROM or the option bytes. When the write is allowed, the unit forwards it as a one-cycle strobe for that region, together with the registered address and data. When it is blocked, the unit drops it and sets a sticky error flag.

There are two independent layers of protection. The first layer is always on. Both program memory and the data area start locked, and each has its own key port. Writing two fixed byte values to that port, in the right order, opens the area. A wrong value, or the right values in the wrong order, bars that area until the next reset. Software can close an open area again with a relock pulse, and a later correct sequence opens it again.

The second layer guards a boot region at the bottom of program memory. Its size is a whole number of 512-byte pages. That size can only be loaded while the programming-mode flag is high. Writes into the boot region are refused even while program memory is open, unless programming mode is active. The incoming write stream uses a valid/ready handshake. The unit never applies back-pressure, so a write is taken in every cycle in which `req_valid` is high.

Top module: `flash_wr_guard`

## Requirements
- R1: After reset, both areas are locked and not barred, `boot_pages` is 0, `wr_err` is 0, and all three write strobes are 0.
- R2: Program memory opens when the byte 0x56 and then the byte 0xAE are written on two successive `key_wr_prog` writes. `unlocked_prog` rises in the cycle after the second write.
- R3: The data area opens when 0xAE and then 0x56 are written on two successive `key_wr_eep` writes. `unlocked_eep` rises in the cycle after the second write.
- R4: A key write with an unexpected value while an area is locked bars that area. A barred area stays locked, and `barred_*` stays high, whatever keys follow, until reset.
- R5: An accepted write to program memory (0x8000–0xFFFF) outside the boot region gives `we_prog` high in the next cycle, with `wr_addr`/`wr_data` equal to the request, only if program memory was open when the write was accepted.
- R6: Writes to the data EEPROM (0x4000–0x407F) and to the option bytes (0x4800–0x487F) need the data area open. They give `we_eep` or `we_opt` respectively one cycle later. At most one strobe is high in any cycle.
- R7: A program-memory write whose offset from 0x8000 is below `boot_pages`×512 is blocked, even when program memory is open, unless `prog_mode` was high when the write was accepted.
- R8: `bsz_wr` loads `boot_pages` only while `prog_mode` is high. Values above 64 saturate to 64. Without `prog_mode` the load has no effect.
- R9: A relock pulse on an open area clears its unlock flag in the next cycle. Relock takes priority over a key write in the same cycle. A later correct key sequence opens the area again.
- R10: `wr_err` is set in the cycle after any blocked write to one of the three regions and stays set until reset. Writes to addresses outside the regions produce no strobe and no error.
- R11: `req_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Write request ready (constant 1) |
| req_addr | input | ADDR_W | Write byte address |
| req_data | input | DATA_W | Write data |
| key_wr_prog | input | 1 | Key write to the program-memory key port |
| key_wr_eep | input | 1 | Key write to the data-area key port |
| key_data | input | 8 | Key byte |
| relock_prog | input | 1 | Close program memory |
| relock_eep | input | 1 | Close data area |
| bsz_wr | input | 1 | Load boot region size |
| bsz_val | input | BSZ_W | Boot region size in pages |
| prog_mode | input | 1 | Programming-mode flag |
| wr_addr | output | ADDR_W | Forwarded write address |
| wr_data | output | DATA_W | Forwarded write data |
| we_prog | output | 1 | Program memory write strobe |
| we_eep | output | 1 | Data EEPROM write strobe |
| we_opt | output | 1 | Option byte write strobe |
| unlocked_prog | output | 1 | Program memory open |
| unlocked_eep | output | 1 | Data area open |
| barred_prog | output | 1 | Program key port barred |
| barred_eep | output | 1 | Data key port barred |
| wr_err | output | 1 | Sticky blocked-write flag |
| boot_pages | output | BSZ_W | Current boot region size in pages |

## Verification
The bench uses the default map: 16-bit addresses, 32 KB of program memory in 64 pages of 512 bytes, a 7-bit size field, and 128-byte EEPROM and option windows. The 7-bit size field lets the bench request sizes up to 127, so saturation at 64 pages is reachable. Page-edge addresses such as 0x87FF and 0x8800 sit on the boot boundary for a 4-page region. A full 64-page region blocks every program address. Random rounds between resets drive both key ports into their open and barred states, and interleave relocks with writes to all three regions.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {
    KS_IDLE   = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2,
    KS_BARRED = 2'd3
  } key_st_t;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_PROG = 2'd1,
    RG_EEP  = 2'd2,
    RG_OPT  = 2'd3
  } region_t;

  localparam logic [7:0] KEY_LO = 8'h56;
  localparam logic [7:0] KEY_HI = 8'hAE;
endpackage

// File: rtl/fwp_key_fsm.sv
module fwp_key_fsm
  import fwp_pkg::*;
#(
  parameter logic [7:0] FIRST  = 8'h56,
  parameter logic [7:0] SECOND = 8'hAE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       relock,
  output logic       open,
  output logic       barred
);
  key_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (relock && st_q == KS_OPEN) begin
      st_d = KS_IDLE;
    end else if (key_wr) begin
      unique case (st_q)
        KS_IDLE:   st_d = (key_data == FIRST)  ? KS_HALF : KS_BARRED;
        KS_HALF:   st_d = (key_data == SECOND) ? KS_OPEN : KS_BARRED;
        KS_OPEN:   st_d = KS_OPEN;
        KS_BARRED: st_d = KS_BARRED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign open   = (st_q == KS_OPEN);
  assign barred = (st_q == KS_BARRED);

  // R4: a barred port never recovers before reset
  p_barred_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    barred |=> (barred && !open));

  // R2 and R3: opening only follows a key write
  p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(key_wr));

  // R9: relock of an open port closes it
  p_relock_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (open && relock) |=> !open);
endmodule

// File: rtl/fwp_addr_decode.sv
module fwp_addr_decode
  import fwp_pkg::*;
#(
  parameter int ADDR_W              = 16,
  parameter int BSZ_W               = 7,
  parameter int unsigned PAGE_BYTES = 512,
  parameter int unsigned PM_BASE    = 32'h8000,
  parameter int unsigned PM_BYTES   = 32768,
  parameter int unsigned EE_BASE    = 32'h4000,
  parameter int unsigned EE_BYTES   = 128,
  parameter int unsigned OPT_BASE   = 32'h4800,
  parameter int unsigned OPT_BYTES  = 128
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BSZ_W-1:0]  boot_pages,
  output region_t           region,
  output logic              in_boot
);
  localparam int PG_SH = $clog2(PAGE_BYTES);

  logic [31:0] a32, off, boot_bytes;
  logic        hit_pm, hit_ee, hit_opt;

  always_comb begin
    a32        = 32'(addr);
    off        = a32 - PM_BASE;
    boot_bytes = 32'(boot_pages) << PG_SH;
    hit_pm     = (a32 >= PM_BASE)  && (a32 < PM_BASE + PM_BYTES);
    hit_ee     = (a32 >= EE_BASE)  && (a32 < EE_BASE + EE_BYTES);
    hit_opt    = (a32 >= OPT_BASE) && (a32 < OPT_BASE + OPT_BYTES);
    if (hit_pm)       region = RG_PROG;
    else if (hit_ee)  region = RG_EEP;
    else if (hit_opt) region = RG_OPT;
    else              region = RG_NONE;
    in_boot = hit_pm && (off < boot_bytes);
  end

  // R7: boot membership only ever applies inside program memory
  always_comb begin
    a_boot_in_prog_r7: assert (!in_boot || region == RG_PROG);
  end
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
  import fwp_pkg::*;
#(
  parameter int ADDR_W              = 16,
  parameter int DATA_W              = 8,
  parameter int unsigned PAGE_BYTES = 512,
  parameter int unsigned PM_BASE    = 32'h8000,
  parameter int unsigned PM_BYTES   = 32768,
  parameter int unsigned EE_BASE    = 32'h4000,
  parameter int unsigned EE_BYTES   = 128,
  parameter int unsigned OPT_BASE   = 32'h4800,
  parameter int unsigned OPT_BYTES  = 128,
  parameter int unsigned PM_PAGES   = PM_BYTES / PAGE_BYTES,
  parameter int BSZ_W               = $clog2(PM_PAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              key_wr_prog,
  input  logic              key_wr_eep,
  input  logic [7:0]        key_data,
  input  logic              relock_prog,
  input  logic              relock_eep,
  input  logic              bsz_wr,
  input  logic [BSZ_W-1:0]  bsz_val,
  input  logic              prog_mode,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              we_prog,
  output logic              we_eep,
  output logic              we_opt,
  output logic              unlocked_prog,
  output logic              unlocked_eep,
  output logic              barred_prog,
  output logic              barred_eep,
  output logic              wr_err,
  output logic [BSZ_W-1:0]  boot_pages
);
  localparam int N_KEY = 2;
  localparam logic [BSZ_W-1:0] MAX_PG = BSZ_W'(PM_PAGES);

  logic [N_KEY-1:0] kwr_v, rl_v, open_v, bar_v;
  assign kwr_v = {key_wr_eep, key_wr_prog};
  assign rl_v  = {relock_eep, relock_prog};

  for (genvar g = 0; g < N_KEY; g++) begin : g_key
    fwp_key_fsm #(
      .FIRST  (g == 0 ? KEY_LO : KEY_HI),
      .SECOND (g == 0 ? KEY_HI : KEY_LO)
    ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (kwr_v[g]),
      .key_data (key_data),
      .relock   (rl_v[g]),
      .open     (open_v[g]),
      .barred   (bar_v[g])
    );
  end

  assign unlocked_prog = open_v[0];
  assign unlocked_eep  = open_v[1];
  assign barred_prog   = bar_v[0];
  assign barred_eep    = bar_v[1];
  assign req_ready     = 1'b1;

  region_t region;
  logic    in_boot;

  fwp_addr_decode #(
    .ADDR_W(ADDR_W), .BSZ_W(BSZ_W), .PAGE_BYTES(PAGE_BYTES),
    .PM_BASE(PM_BASE), .PM_BYTES(PM_BYTES),
    .EE_BASE(EE_BASE), .EE_BYTES(EE_BYTES),
    .OPT_BASE(OPT_BASE), .OPT_BYTES(OPT_BYTES)
  ) u_dec (
    .addr       (req_addr),
    .boot_pages (boot_pages),
    .region     (region),
    .in_boot    (in_boot)
  );

  logic allow, take;
  always_comb begin
    unique case (region)
      RG_PROG: allow = open_v[0] && (!in_boot || prog_mode);
      RG_EEP:  allow = open_v[1];
      RG_OPT:  allow = open_v[1];
      default: allow = 1'b0;
    endcase
    take = req_valid && req_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_prog    <= 1'b0;
      we_eep     <= 1'b0;
      we_opt     <= 1'b0;
      wr_err     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      boot_pages <= '0;
    end else begin
      we_prog <= take && allow && region == RG_PROG;
      we_eep  <= take && allow && region == RG_EEP;
      we_opt  <= take && allow && region == RG_OPT;
      if (take && !allow && region != RG_NONE) wr_err <= 1'b1;
      if (take) begin
        wr_addr <= req_addr;
        wr_data <= req_data;
      end
      if (bsz_wr && prog_mode)
        boot_pages <= (bsz_val > MAX_PG) ? MAX_PG : bsz_val;
    end
  end

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_prog, we_eep, we_opt}));

  p_prog_needs_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_prog |-> $past(open_v[0]));

  p_data_needs_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_eep || we_opt) |-> $past(open_v[1]));

  p_boot_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we_prog |-> ($past(prog_mode) || !$past(in_boot)));

  p_size_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(boot_pages) |-> $past(prog_mode));

  p_size_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_pages <= MAX_PG);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
endmodule

// File: tb/sim_flash_wr_guard.sv
module sim_flash_wr_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, key_wr_prog = 0, key_wr_eep = 0;
  logic relock_prog = 0, relock_eep = 0, bsz_wr = 0, prog_mode = 0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_data = '0, key_data = '0;
  logic [6:0]  bsz_val = '0;
  logic req_ready, we_prog, we_eep, we_opt, unlocked_prog, unlocked_eep;
  logic barred_prog, barred_eep, wr_err;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [6:0]  boot_pages;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wr_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .key_wr_prog(key_wr_prog),
    .key_wr_eep(key_wr_eep), .key_data(key_data), .relock_prog(relock_prog),
    .relock_eep(relock_eep), .bsz_wr(bsz_wr), .bsz_val(bsz_val),
    .prog_mode(prog_mode), .wr_addr(wr_addr), .wr_data(wr_data),
    .we_prog(we_prog), .we_eep(we_eep), .we_opt(we_opt),
    .unlocked_prog(unlocked_prog), .unlocked_eep(unlocked_eep),
    .barred_prog(barred_prog), .barred_eep(barred_eep), .wr_err(wr_err),
    .boot_pages(boot_pages));

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  // model: key state 0 idle, 1 half, 2 open, 3 barred; [0] program, [1] data
  int mst[2];
  int m_boot;
  bit m_err;
  bit [7:0] k1[2] = '{8'h56, 8'hAE};
  bit [7:0] k2[2] = '{8'hAE, 8'h56};

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // 0 none, 1 program, 2 eeprom, 3 option
  function automatic int region_of(bit [15:0] a);
    if (a >= 16'h8000) return 1;
    if (a >= 16'h4000 && a < 16'h4080) return 2;
    if (a >= 16'h4800 && a < 16'h4880) return 3;
    return 0;
  endfunction

  function automatic int key_next(int st, bit wr, bit [7:0] d, int i, bit rl);
    if (rl && st == 2) return 0;
    if (!wr) return st;
    if (st == 0) return (d == k1[i]) ? 1 : 3;
    if (st == 1) return (d == k2[i]) ? 2 : 3;
    return st;
  endfunction

  task automatic cyc(bit v, bit [15:0] a, bit [7:0] d, bit kp, bit ke,
                     bit [7:0] kd, bit rp, bit re, bit bw, bit [6:0] bv, bit pm);
    int rg;
    bit inb, alw, e_wp, e_we, e_wo;
    string tp, tu;
    @(negedge clk);
    req_valid = v; req_addr = a; req_data = d; key_wr_prog = kp;
    key_wr_eep = ke; key_data = kd; relock_prog = rp; relock_eep = re;
    bsz_wr = bw; bsz_val = bv; prog_mode = pm;
    rg  = region_of(a);
    inb = (rg == 1) && (int'(a) - 32'h8000 < m_boot * 512);
    case (rg)
      1: alw = (mst[0] == 2) && (!inb || pm);
      2, 3: alw = (mst[1] == 2);
      default: alw = 0;
    endcase
    e_wp = v && alw && rg == 1;
    e_we = v && alw && rg == 2;
    e_wo = v && alw && rg == 3;
    if (v && !alw && rg != 0) m_err = 1;
    tp = (rg == 1 && inb) ? "R7 boot guard" : "R5 program write";
    tu = (rp && mst[0] == 2) ? "R9 relock" : "R2 program key";
    mst[0] = key_next(mst[0], kp, kd, 0, rp);
    mst[1] = key_next(mst[1], ke, kd, 1, re);
    if (bw && pm) m_boot = (bv > 64) ? 64 : bv;
    @(posedge clk); #1;
    chk(tp, we_prog, e_wp);
    chk("R6 eeprom strobe", we_eep, e_we);
    chk("R6 option strobe", we_opt, e_wo);
    if (e_wp || e_we || e_wo) begin
      chk("R5 forwarded addr", wr_addr, a);
      chk("R5 forwarded data", wr_data, d);
    end
    chk("R10 sticky error", wr_err, m_err);
    chk(tu, unlocked_prog, mst[0] == 2);
    chk((re && !unlocked_eep) ? "R9 relock" : "R3 data key", unlocked_eep, mst[1] == 2);
    chk("R4 program barred", barred_prog, mst[0] == 3);
    chk("R4 data barred", barred_eep, mst[1] == 3);
    chk("R8 boot size", boot_pages, m_boot);
    chk("R11 ready", req_ready, 1);
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(bit [15:0] a, bit [7:0] d, bit pm);
    cyc(1, a, d, 0, 0, 0, 0, 0, 0, 0, pm);
  endtask
  task automatic keyp(bit [7:0] k); cyc(0, 0, 0, 1, 0, k, 0, 0, 0, 0, 0); endtask
  task automatic keye(bit [7:0] k); cyc(0, 0, 0, 0, 1, k, 0, 0, 0, 0, 0); endtask
  task automatic bsz(bit [6:0] n, bit pm); cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, n, pm); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; key_wr_prog = 0; key_wr_eep = 0;
    relock_prog = 0; relock_eep = 0; bsz_wr = 0; prog_mode = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    mst[0] = 0; mst[1] = 0; m_boot = 0; m_err = 0;
    #1;
    chk("R1 reset strobes", {we_prog, we_eep, we_opt}, 0);
    chk("R1 reset flags", {unlocked_prog, unlocked_eep, barred_prog, barred_eep, wr_err}, 0);
    chk("R1 reset boot size", boot_pages, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R5, R10: locked program write is blocked and flagged
    wr(16'h9000, 8'h11, 0);
    // R10: outside address leaves nothing behind
    do_reset();
    wr(16'h1000, 8'h22, 0);
    // R2, R3 unlock sequences
    keyp(8'h56); keyp(8'hAE);
    wr(16'h9000, 8'h33, 0);
    keye(8'hAE); keye(8'h56);
    wr(16'h4010, 8'h44, 0);
    wr(16'h4810, 8'h55, 0);
    wr(16'h4880, 8'h56, 0);
    // R8: load without programming mode ignored, then loaded
    bsz(7'd4, 0);
    bsz(7'd4, 1);
    // R7 boundaries for a 4-page region
    wr(16'h8100, 8'h66, 0);
    wr(16'h8100, 8'h67, 1);
    wr(16'h87FF, 8'h68, 0);
    wr(16'h8800, 8'h69, 0);
    // R8 saturation, whole program memory guarded
    bsz(7'd100, 1);
    wr(16'hFFFF, 8'h6A, 0);
    bsz(7'd0, 1);
    // R9 relock, priority over same-cycle key, reopen
    cyc(0, 0, 0, 1, 0, 8'h56, 1, 0, 0, 0, 0);
    wr(16'h9000, 8'h77, 0);
    keyp(8'hAE);
    idle();
    do_reset();
    keyp(8'h56); keyp(8'hAE);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    keyp(8'h56); keyp(8'hAE);
    wr(16'hA000, 8'h78, 0);
    // R4: wrong order bars the port for good
    do_reset();
    keyp(8'hAE); keyp(8'h56); keyp(8'hAE);
    wr(16'h9000, 8'h79, 0);
    keye(8'h56); keye(8'hAE); keye(8'h56);
    wr(16'h4000, 8'h7A, 0);
    // random rounds
    for (int r = 0; r < 6; r++) begin
      do_reset();
      for (int i = 0; i < 500; i++) begin
        bit [15:0] a;
        bit [7:0]  kd;
        case ($urandom % 5)
          0: a = 16'h8000 + 16'($urandom % 32768);
          1: a = 16'h4000 + 16'($urandom % 128);
          2: a = 16'h4800 + 16'($urandom % 128);
          3: a = 16'h8000 + 16'($urandom % 4096);
          default: a = 16'($urandom);
        endcase
        case ($urandom % 4)
          0: kd = 8'h56;
          1: kd = 8'hAE;
          default: kd = 8'($urandom);
        endcase
        if ($urandom % 8 != 0 && kd != 8'h56 && kd != 8'hAE) kd = 8'h56;
        cyc(($urandom % 2) == 1, a, 8'($urandom),
            ($urandom % 6) == 0, ($urandom % 6) == 0, kd,
            ($urandom % 40) == 0, ($urandom % 40) == 0,
            ($urandom % 16) == 0, 7'($urandom), ($urandom % 3) == 0);
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule